// File: doc/BRIEF.md
# DDR3 Refresh and Self-Refresh Sequencer

This block sits beside the command path of a DDR3 memory controller. It decides when the device must be refreshed and brings the controller in and out of self-refresh. While the controller is in normal operation, a free-running interval timer marks when a periodic auto-refresh is due. The sequencer waits until the command path reports idle. It then issues a precharge-all strobe and a refresh strobe in consecutive cycles, and it holds the host bus stalled for the refresh cycle time before normal operation resumes.

A self-refresh request overrides the interval timer. From normal operation the sequencer goes straight to precharge-all, whatever the busy input says, and then drops CKE. CKE stays low while the request stays high. When the request is withdrawn, CKE goes high again. The sequencer waits out the exit settling time, always issues one extra refresh, and waits out the refresh cycle time before it releases the stall. The forced refresh also restarts the interval timer. All delays are whole controller cycles, rounded up from nanosecond parameters and the clock period. At the defaults (10 ns clock, 7800 ns interval, 300 ns refresh cycle, 1200 ns exit settling) these are 780, 30 and 120 cycles.

There are six states, and each is exposed on `state_o` by its code:

| State | Code | Behaviour |
|---|---|---|
| NORMAL | 0 | Commands flow and the bus is not stalled. |
| PREALL | 1 | Precharge-all strobe for one cycle. |
| REFRESH | 2 | Refresh strobe for one cycle. |
| RFC_WAIT | 3 | Refresh cycle time elapses. |
| SR_ACTIVE | 4 | CKE is low. |
| SR_EXIT | 5 | CKE is high again and the exit settling time elapses. |

The transitions are as follows:

- NORMAL goes to PREALL when a request is present (the self-refresh path), or when refresh is due and the command path is idle (the periodic path).
- PREALL goes to SR_ACTIVE on the self-refresh path, or to REFRESH on the periodic path.
- SR_ACTIVE goes to SR_EXIT when the request is low.
- SR_EXIT goes to REFRESH when the settle count ends.
- REFRESH always goes to RFC_WAIT.
- RFC_WAIT goes to NORMAL when the wait count ends.

Top module: `ddr3_refresh_sequencer`

## Requirements
- R1: While reset is held, CKE is high, both strobes are low, the stall is low and the state code is 0.
- R2: With no self-refresh request and the command path idle, the first refresh strobe comes 780 cycles after reset is released, and later ones follow every 780 cycles. Each refresh strobe is preceded, in the cycle directly before it, by a precharge-all strobe.
- R3: A due periodic refresh is held off while the busy input is high. The precharge-all strobe appears in the cycle after the first cycle in which busy is sampled low.
- R4: After a periodic refresh the stall stays high for 31 cycles in a row: one precharge-all cycle plus the 30-cycle refresh cycle time that starts with the refresh strobe.
- R5: A self-refresh request sampled in NORMAL gives a precharge-all strobe in the next cycle, with no refresh strobe before CKE falls. CKE falls in the cycle after the precharge-all strobe.
- R6: CKE stays low for as long as the request stays high. A request held for L sampled cycles, with L of 2 or more, gives L-1 cycles of CKE low.
- R7: Once the request is low, CKE returns high in the following cycle. Exactly one refresh strobe follows, 120 cycles after CKE rises. The stall stays high for 150 cycles from the rise, and no precharge-all is issued during the exit.
- R8: The precharge-all and refresh strobes are each one cycle wide and never high together.
- R9: If a self-refresh request arrives in the same cycle in which a periodic refresh falls due, the self-refresh path is taken and no refresh strobe is issued before self-refresh. The next periodic refresh comes 780 cycles after the forced exit refresh.
- R10: A request that is high for a single sampled cycle still completes entry, gives one cycle of CKE low and then exits normally.
- R11: The state code is 4 in exactly the cycles in which CKE is low. It is 5 in the cycle CKE rises and 2 in the cycle of each refresh strobe.
- R12: A self-refresh request is acted on even while the busy input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req_i | input | 1 | Self-refresh request, level sensitive |
| cmd_busy_i | input | 1 | Command path has work in flight; defers periodic refresh |
| cke_o | output | 1 | DDR3 clock-enable level |
| pre_all_o | output | 1 | One-cycle precharge-all command strobe |
| ref_o | output | 1 | One-cycle refresh command strobe |
| state_o | output | 3 | Current state code |
| stall_o | output | 1 | Host bus stall |

## Verification
The periodic refresh timer and the self-refresh request can both call for precharge-all in the same NORMAL cycle. To provoke this, the bench counts cycles from reset and from each logged refresh strobe, and it raises the request in the exact cycle in which the 780-cycle interval expires. The bench then judges the outcome at the ports. The precharge-all strobe must be followed by CKE falling, not by a refresh strobe. Exactly one refresh strobe must appear, 120 cycles after CKE rises. The next periodic strobe must come 780 cycles after that forced one.

// File: rtl/rfsh_seq_pkg.sv
`timescale 1ns/1ps
package rfsh_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_NORMAL    = 3'd0,
        SEQ_PREALL    = 3'd1,
        SEQ_REFRESH   = 3'd2,
        SEQ_RFC_WAIT  = 3'd3,
        SEQ_SR_ACTIVE = 3'd4,
        SEQ_SR_EXIT   = 3'd5
    } seq_state_e;

    // Round a duration in ns up to whole clock cycles.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
`timescale 1ns/1ps
// Free-running refresh interval counter. It is cleared on the edge that
// enters the refresh state, so its count equals the cycles since the last
// refresh strobe. It flags due two cycles before the interval ends, which
// leaves room for the precharge-all cycle.
module rfsh_interval_timer #(
    parameter int unsigned INTERVAL_CYC = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic due_o
);
    localparam int unsigned CW = $clog2(INTERVAL_CYC + 1);
    localparam logic [CW-1:0] DUE_AT = CW'(INTERVAL_CYC - 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart_i) begin
            cnt <= '0;
        end else if (cnt != DUE_AT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign due_o = (cnt == DUE_AT);
endmodule

// File: rtl/rfsh_wait_timer.sv
`timescale 1ns/1ps
// Down counter that is shared by the exit-settle wait and the refresh-cycle wait.
module rfsh_wait_timer #(
    parameter int unsigned MAX_CYC = 120,
    localparam int unsigned CW = $clog2(MAX_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          done_o
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= load_val_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done_o = (cnt == '0);
endmodule

// File: rtl/rfsh_out_decode.sv
`timescale 1ns/1ps
// All sequencer outputs are decoded from the state register alone.
module rfsh_out_decode
    import rfsh_seq_pkg::*;
(
    input  seq_state_e  state_i,
    output logic        cke_o,
    output logic        pre_all_o,
    output logic        ref_o,
    output logic        stall_o,
    output logic [2:0]  state_code_o
);
    always_comb begin
        cke_o        = 1'b1;
        pre_all_o    = 1'b0;
        ref_o        = 1'b0;
        stall_o      = 1'b1;
        state_code_o = state_i;
        unique case (state_i)
            SEQ_NORMAL:    stall_o   = 1'b0;
            SEQ_PREALL:    pre_all_o = 1'b1;
            SEQ_REFRESH:   ref_o     = 1'b1;
            SEQ_RFC_WAIT:  ;
            SEQ_SR_ACTIVE: cke_o     = 1'b0;
            SEQ_SR_EXIT:   ;
            default:       ;
        endcase
    end
endmodule

// File: rtl/ddr3_refresh_sequencer.sv
`timescale 1ns/1ps
module ddr3_refresh_sequencer
    import rfsh_seq_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS       = 10000,
    parameter int unsigned REFRESH_INTERVAL_NS = 7800,
    parameter int unsigned REFRESH_CYCLE_NS    = 300,
    parameter int unsigned SR_EXIT_SETTLE_NS   = 1200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sr_req_i,
    input  logic       cmd_busy_i,
    output logic       cke_o,
    output logic       pre_all_o,
    output logic       ref_o,
    output logic [2:0] state_o,
    output logic       stall_o
);
    localparam int unsigned REFI_CYC = ns_to_cycles(REFRESH_INTERVAL_NS, CLK_PERIOD_PS);
    localparam int unsigned RFC_CYC  = ns_to_cycles(REFRESH_CYCLE_NS, CLK_PERIOD_PS);
    localparam int unsigned XS_CYC   = ns_to_cycles(SR_EXIT_SETTLE_NS, CLK_PERIOD_PS);
    localparam int unsigned WAIT_MAX = (XS_CYC > RFC_CYC) ? XS_CYC : RFC_CYC;
    localparam int unsigned WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam logic [WAIT_W-1:0] XS_LOAD  = WAIT_W'(XS_CYC - 1);
    localparam logic [WAIT_W-1:0] RFC_LOAD = WAIT_W'(RFC_CYC - 2);

    seq_state_e        state, state_nx;
    logic              sr_path, sr_path_nx;
    logic              refresh_due;
    logic              wait_done;
    logic              wait_load;
    logic [WAIT_W-1:0] wait_val;

    rfsh_interval_timer #(.INTERVAL_CYC(REFI_CYC)) i_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (state_nx == SEQ_REFRESH),
        .due_o     (refresh_due)
    );

    rfsh_wait_timer #(.MAX_CYC(WAIT_MAX)) i_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wait_load),
        .load_val_i (wait_val),
        .done_o     (wait_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_NORMAL;
            sr_path <= 1'b0;
        end else begin
            state   <= state_nx;
            sr_path <= sr_path_nx;
        end
    end

    // Next state and wait-timer loading
    always_comb begin
        state_nx   = state;
        sr_path_nx = sr_path;
        wait_load  = 1'b0;
        wait_val   = RFC_LOAD;
        unique case (state)
            SEQ_NORMAL: begin
                if (sr_req_i) begin
                    state_nx   = SEQ_PREALL;
                    sr_path_nx = 1'b1;
                end else if (refresh_due && !cmd_busy_i) begin
                    state_nx   = SEQ_PREALL;
                    sr_path_nx = 1'b0;
                end
            end
            SEQ_PREALL: begin
                state_nx = sr_path ? SEQ_SR_ACTIVE : SEQ_REFRESH;
            end
            SEQ_SR_ACTIVE: begin
                if (!sr_req_i) begin
                    state_nx  = SEQ_SR_EXIT;
                    wait_load = 1'b1;
                    wait_val  = XS_LOAD;
                end
            end
            SEQ_SR_EXIT: begin
                if (wait_done) begin
                    state_nx = SEQ_REFRESH;
                end
            end
            SEQ_REFRESH: begin
                state_nx   = SEQ_RFC_WAIT;
                sr_path_nx = 1'b0;
                wait_load  = 1'b1;
                wait_val   = RFC_LOAD;
            end
            SEQ_RFC_WAIT: begin
                if (wait_done) begin
                    state_nx = SEQ_NORMAL;
                end
            end
            default: state_nx = SEQ_NORMAL;
        endcase
    end

    rfsh_out_decode i_decode (
        .state_i      (state),
        .cke_o        (cke_o),
        .pre_all_o    (pre_all_o),
        .ref_o        (ref_o),
        .stall_o      (stall_o),
        .state_code_o (state_o)
    );
endmodule

// File: rtl/rfsh_seq_checker.sv
`timescale 1ns/1ps
module rfsh_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sr_req_i,
    input logic       cke_o,
    input logic       pre_all_o,
    input logic       ref_o,
    input logic [2:0] state_o,
    input logic       stall_o
);
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_all_o && ref_o));

    p_pre_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_o |=> !pre_all_o);

    p_ref_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_o |=> !ref_o);

    p_sr_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && sr_req_i) |=> pre_all_o);

    p_cke_fall_after_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |-> $past(pre_all_o));

    p_cke_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && sr_req_i) |=> !cke_o);

    p_exit_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && !sr_req_i) |=> cke_o);

    p_stall_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> stall_o);

    p_ref_after_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 3'd5 && state_o != 3'd5) |-> ref_o);
endmodule

bind ddr3_refresh_sequencer rfsh_seq_checker i_rfsh_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sr_req_i  (sr_req_i),
    .cke_o     (cke_o),
    .pre_all_o (pre_all_o),
    .ref_o     (ref_o),
    .state_o   (state_o),
    .stall_o   (stall_o)
);

// File: tb/test_ddr3_refresh_sequencer.sv
`timescale 1ns/1ps
module test_ddr3_refresh_sequencer;
    localparam int REFI = 780;
    localparam int RFC  = 30;
    localparam int XS   = 120;
    localparam int NVEC = 6;
    // Vector table: request length, busy level, expected CKE-low cycles
    localparam int VEC_LEN  [NVEC] = '{1, 2, 3, 8, 40, 200};
    localparam int VEC_BUSY [NVEC] = '{0, 1, 0, 1, 0, 1};
    localparam int VEC_EXP  [NVEC] = '{1, 1, 2, 7, 39, 199};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_req = 1'b0;
    logic busy = 1'b0;
    logic cke, pre_all, refc, stall;
    logic [2:0] state;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int ref_n = 0;
    int pre_n = 0;
    int ref_at [32];
    int pre_at [32];
    int stall_run = 0;
    int last_stall_run = 0;
    int r8_viol = 0;
    int r11_viol = 0;

    always #5 clk = ~clk;

    ddr3_refresh_sequencer i_ddr3_refresh_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_req_i   (sr_req),
        .cmd_busy_i (busy),
        .cke_o      (cke),
        .pre_all_o  (pre_all),
        .ref_o      (refc),
        .state_o    (state),
        .stall_o    (stall)
    );

    // Event log, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0;
        end else begin
            cyc = cyc + 1;
            if (pre_all) begin
                if (pre_n < 32) pre_at[pre_n] = cyc;
                pre_n = pre_n + 1;
            end
            if (refc) begin
                if (ref_n < 32) ref_at[ref_n] = cyc;
                ref_n = ref_n + 1;
            end
            if (stall) stall_run = stall_run + 1;
            else if (stall_run != 0) begin
                last_stall_run = stall_run;
                stall_run = 0;
            end
            if ((pre_all && refc) || (pre_all && $past(pre_all)) || (refc && $past(refc)))
                r8_viol = r8_viol + 1;
            if ((!cke) != (state == 3'd4)) r11_viol = r11_viol + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic run_sr(input int len, input int bsy, input int exp_low, output int ref_abs);
        int pre_pos = -1;
        int pre_cnt = 0;
        int ref_cnt = 0;
        int ref_pos = -1;
        int low = 0;
        int rise = -1;
        int st_after = 0;
        int rise_state = -1;
        int ref_state = -1;
        ref_abs = -1;
        @(negedge clk);
        #1;
        while (state != 3'd0) begin
            @(negedge clk);
            #1;
        end
        sr_req = 1'b1;
        busy = bsy[0];
        for (int n = 1; n < 2000; n++) begin
            @(negedge clk);
            #1;
            if (pre_all) begin
                pre_cnt++;
                if (pre_pos < 0) pre_pos = n;
            end
            if (refc) begin
                ref_cnt++;
                ref_pos = n;
                ref_abs = cyc;
                ref_state = state;
            end
            if (!cke) low++;
            if (cke && low > 0 && rise < 0) begin
                rise = n;
                rise_state = state;
            end
            if (rise >= 0 && stall) st_after++;
            if (n == len) sr_req = 1'b0;
            if (rise >= 0 && !stall) break;
        end
        busy = 1'b0;
        chk(pre_pos == 1, "R5 precharge-all one cycle after request", pre_pos, 1);
        if (bsy != 0) chk(pre_pos == 1, "R12 request honoured while busy", pre_pos, 1);
        chk(low == exp_low, (len == 1) ? "R10 single-cycle request CKE-low cycles" : "R6 CKE-low cycles", low, exp_low);
        chk(rise == ((len > 2) ? len : 2) + 1, "R7 CKE rise cycle", rise, ((len > 2) ? len : 2) + 1);
        chk(ref_cnt == 1, "R7 exactly one refresh on exit", ref_cnt, 1);
        chk(ref_pos - rise == XS, "R7 refresh delay after CKE rise", ref_pos - rise, XS);
        chk(st_after == XS + RFC, "R7 stall cycles after CKE rise", st_after, XS + RFC);
        chk(pre_cnt == 1, "R7 no precharge-all during exit", pre_cnt, 1);
        chk(rise_state == 5, "R11 state code at CKE rise", rise_state, 5);
        chk(ref_state == 2, "R11 state code at refresh", ref_state, 2);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        checks = checks + 1;
        fails = fails + 1;
        $display("FAIL watchdog R1..: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int sr_ref;
        int base;
        repeat (3) @(negedge clk);
        #1;
        chk(cke == 1'b1, "R1 CKE high in reset", cke, 1);
        chk(pre_all == 1'b0 && refc == 1'b0, "R1 strobes low in reset", {pre_all, refc}, 0);
        chk(stall == 1'b0, "R1 stall low in reset", stall, 0);
        chk(state == 3'd0, "R1 state code in reset", state, 0);
        rst_n = 1'b1;

        // Periodic refresh, then a refresh deferred by busy
        wait_cyc(900);
        chk(last_stall_run == RFC + 1, "R4 stall run after periodic refresh", last_stall_run, RFC + 1);
        wait_cyc(2300);
        busy = 1'b1;
        wait_cyc(2400);
        busy = 1'b0;
        wait_cyc(2410);
        chk(pre_at[0] == REFI - 1, "R2 first precharge-all", pre_at[0], REFI - 1);
        chk(ref_at[0] == REFI, "R2 first refresh", ref_at[0], REFI);
        chk(ref_at[1] - ref_at[0] == REFI, "R2 refresh interval", ref_at[1] - ref_at[0], REFI);
        chk(pre_at[1] == ref_at[1] - 1, "R2 precharge-all precedes refresh", pre_at[1], ref_at[1] - 1);
        chk(pre_at[2] == 2401, "R3 precharge-all after busy drops", pre_at[2], 2401);
        chk(ref_at[2] == 2402, "R3 deferred refresh", ref_at[2], 2402);
        chk(pre_n == 3, "R3 no precharge-all while busy", pre_n, 3);

        // Collision: request in the cycle the refresh falls due (R9)
        wait_cyc(ref_at[2] + REFI - 3);
        run_sr(10, 0, 9, sr_ref);
        chk(ref_n == 4, "R9 no periodic refresh on collision", ref_n, 4);
        base = ref_n;
        while (ref_n == base) begin
            @(negedge clk);
            #1;
        end
        chk(ref_at[base] - sr_ref == REFI, "R9 interval restarts at exit refresh", ref_at[base] - sr_ref, REFI);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            int r;
            run_sr(VEC_LEN[i], VEC_BUSY[i], VEC_EXP[i], r);
        end

        chk(r8_viol == 0, "R8 strobe width and exclusion", r8_viol, 0);
        chk(r11_viol == 0, "R11 state code 4 exactly while CKE low", r11_viol, 0);
        finish_run();
    end
endmodule